// File: doc/BRIEF.md
# ECC-Protected Configuration Word Decoder

This block checks a 64-bit one-time configuration word when it is loaded. The word carries 56 data bits and 8 check bits, and the block repairs any single flipped bit. It reports whether the word was clean, repaired or beyond repair. It also puts out the repaired word and a 5-bit flag field taken from fixed positions in it. In that field, 1 selects the protected variant and 0 the standard variant.

Six Hamming check bits sit at the power-of-two positions 1 to 32, so their syndrome gives the position of a single flipped bit. Two more parity bits replace the usual single overall parity bit. Bit 0 covers the data bits only, and bit 63 covers the six Hamming check bits only. Together they tell a flipped data bit from a flipped check bit, locate an error in either parity bit, and expose every two-bit error. The result is registered. It appears one cycle after the load strobe, together with a one-cycle done pulse, and holds until the next load, so it can be read like a register.

Top module: `ecc_cfg_word`

## Requirements
- R1: Layout and parity: check bits sit at positions 0, 1, 2, 4, 8, 16, 32 and 63, and the data bits fill every other position. The parity sense is even. The check bit at position 2^k makes the XOR of all positions 1..62 whose index has bit k set come to zero. Bit 0 equals the XOR of the 56 data bits. Bit 63 equals the XOR of the bits at positions 1, 2, 4, 8, 16 and 32. A word that obeys these rules gives err_o=0, fixed_o=0 and uncorr_o=0, and word_o equals the input.
- R2: A word with exactly one data bit flipped comes out repaired, with err_o=1, fixed_o=1 and uncorr_o=0.
- R3: A word with exactly one of the bits at positions 1, 2, 4, 8, 16 or 32 flipped comes out repaired, with err_o=1 and fixed_o=1.
- R4: A word with only bit 0 or only bit 63 flipped comes out repaired, with err_o=1 and fixed_o=1.
- R5: A word with any two bits flipped gives err_o=1, uncorr_o=1 and fixed_o=0, and word_o equals the input unchanged.
- R6: done_o is high for exactly the one cycle after each cycle in which load_i is high. The other outputs take their new values in that same cycle.
- R7: While load_i is low, word_o, flags_o, err_o, fixed_o and uncorr_o keep their values, whatever word_i does.
- R8: flags_o equals bits 62 down to 58 of the repaired word (bit 58 is flags_o[0]), so a flipped flag bit is repaired before it is exposed.
- R9: While rst_ni is low, every output is zero.
- R10: fixed_o and uncorr_o are never both high, and err_o is high exactly when one of them is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Strobe: capture and check word_i |
| word_i | input | 64 | Stored configuration word with check bits |
| word_o | output | 64 | Repaired word, or the raw word when it cannot be repaired |
| flags_o | output | 5 | Flag field from bits 62..58 of word_o |
| err_o | output | 1 | Any error detected |
| fixed_o | output | 1 | A single error was repaired |
| uncorr_o | output | 1 | The error cannot be repaired |
| done_o | output | 1 | One-cycle pulse when a result is new |

## Verification
The bench builds the decoder with its default parameters: a 6-bit syndrome (and so a 64-bit word), with the flag field at bit 58 and 5 bits wide. With these values the bench can flip each of the 64 positions on its own, the two lone-parity positions included. The bench also tries a few hundred random two-bit flips, which cover every mix of data, Hamming and parity positions. Its model classifies each word by brute force, trying every single flip against the parity rules, so it shares no structure with the syndrome decoder.

// File: rtl/ecc_cfg_pkg.sv
package ecc_cfg_pkg;

    typedef enum logic [1:0] {
        CLS_CLEAN = 2'd0,
        CLS_FIXED = 2'd1,
        CLS_BAD   = 2'd2
    } ecc_cls_e;

    function automatic logic is_pow2(input int unsigned v);
        return (v != 0) && ((v & (v - 1)) == 0);
    endfunction

endpackage

// File: rtl/ecc_syndrome.sv
module ecc_syndrome #(
    parameter int SYN_W  = 6,
    parameter int WORD_W = 64
) (
    input  logic [WORD_W-1:0] word_i,
    output logic [SYN_W-1:0]  syn_o,
    output logic              dpar_fail_o,
    output logic              cpar_fail_o
);
    import ecc_cfg_pkg::*;

    // Hamming syndrome over positions 1..WORD_W-2, plus the two split parity checks
    always_comb begin
        syn_o       = '0;
        dpar_fail_o = word_i[0];
        cpar_fail_o = word_i[WORD_W-1];
        for (int p = 1; p < WORD_W - 1; p++) begin
            for (int k = 0; k < SYN_W; k++) begin
                if (((p >> k) & 1) == 1) begin
                    syn_o[k] = syn_o[k] ^ word_i[p];
                end
            end
            if (is_pow2(p)) begin
                cpar_fail_o = cpar_fail_o ^ word_i[p];
            end else begin
                dpar_fail_o = dpar_fail_o ^ word_i[p];
            end
        end
    end

endmodule

// File: rtl/ecc_classify.sv
module ecc_classify #(
    parameter int SYN_W  = 6,
    parameter int WORD_W = 64
) (
    input  logic [SYN_W-1:0]     syn_i,
    input  logic                 dpar_fail_i,
    input  logic                 cpar_fail_i,
    output logic [WORD_W-1:0]    flip_o,
    output ecc_cfg_pkg::ecc_cls_e cls_o
);
    import ecc_cfg_pkg::*;

    localparam logic [SYN_W-1:0] SYN_ALL = '1;

    logic syn_zero;
    logic syn_chk;
    logic syn_data;

    always_comb begin
        syn_zero = (syn_i == '0);
        syn_chk  = !syn_zero && ((syn_i & (syn_i - 1'b1)) == '0);
        syn_data = !syn_zero && !syn_chk && (syn_i != SYN_ALL);
        flip_o   = '0;
        cls_o    = CLS_BAD;
        if (syn_zero && !dpar_fail_i && !cpar_fail_i) begin
            cls_o = CLS_CLEAN;
        end else if (syn_zero && dpar_fail_i && !cpar_fail_i) begin
            cls_o     = CLS_FIXED;
            flip_o[0] = 1'b1;
        end else if (syn_zero && !dpar_fail_i && cpar_fail_i) begin
            cls_o            = CLS_FIXED;
            flip_o[WORD_W-1] = 1'b1;
        end else if (syn_data && dpar_fail_i && !cpar_fail_i) begin
            cls_o         = CLS_FIXED;
            flip_o[syn_i] = 1'b1;
        end else if (syn_chk && !dpar_fail_i && cpar_fail_i) begin
            cls_o         = CLS_FIXED;
            flip_o[syn_i] = 1'b1;
        end
    end

endmodule

// File: rtl/ecc_cfg_word.sv
module ecc_cfg_word #(
    parameter int SYN_W    = 6,
    parameter int FLAG_LSB = 58,
    parameter int FLAG_W   = 5
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     load_i,
    input  logic [(1<<SYN_W)-1:0]    word_i,
    output logic [(1<<SYN_W)-1:0]    word_o,
    output logic [FLAG_W-1:0]        flags_o,
    output logic                     err_o,
    output logic                     fixed_o,
    output logic                     uncorr_o,
    output logic                     done_o
);
    import ecc_cfg_pkg::*;

    localparam int WORD_W = 1 << SYN_W;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              err;
        logic              fixed;
        logic              uncorr;
        logic              done;
    } res_t;

    logic [SYN_W-1:0]  syn;
    logic              dpar_fail;
    logic              cpar_fail;
    logic [WORD_W-1:0] flip;
    ecc_cls_e          cls;
    res_t              st_d, st_q;

    ecc_syndrome #(.SYN_W(SYN_W), .WORD_W(WORD_W)) u_syn (
        .word_i      (word_i),
        .syn_o       (syn),
        .dpar_fail_o (dpar_fail),
        .cpar_fail_o (cpar_fail)
    );

    ecc_classify #(.SYN_W(SYN_W), .WORD_W(WORD_W)) u_cls (
        .syn_i       (syn),
        .dpar_fail_i (dpar_fail),
        .cpar_fail_i (cpar_fail),
        .flip_o      (flip),
        .cls_o       (cls)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (load_i) begin
            st_d.done   = 1'b1;
            st_d.word   = word_i ^ flip;
            st_d.err    = (cls != CLS_CLEAN);
            st_d.fixed  = (cls == CLS_FIXED);
            st_d.uncorr = (cls == CLS_BAD);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_o   = st_q.word;
    assign flags_o  = st_q.word[FLAG_LSB +: FLAG_W];
    assign err_o    = st_q.err;
    assign fixed_o  = st_q.fixed;
    assign uncorr_o = st_q.uncorr;
    assign done_o   = st_q.done;

endmodule

// File: rtl/ecc_cfg_word_chk.sv
module ecc_cfg_word_chk #(
    parameter int SYN_W    = 6,
    parameter int FLAG_LSB = 58,
    parameter int FLAG_W   = 5
) (
    input logic                  clk_i,
    input logic                  rst_ni,
    input logic                  load_i,
    input logic [(1<<SYN_W)-1:0] word_i,
    input logic [(1<<SYN_W)-1:0] word_o,
    input logic [FLAG_W-1:0]     flags_o,
    input logic                  err_o,
    input logic                  fixed_o,
    input logic                  uncorr_o,
    input logic                  done_o
);

    p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o == $past(load_i));

    p_clean_raw_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !err_o) |-> (word_o == $past(word_i)));

    p_one_flip_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && fixed_o) |-> ($countones(word_o ^ $past(word_i)) == 1));

    p_bad_raw_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && uncorr_o) |-> (word_o == $past(word_i)));

    p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(load_i) |-> ($stable(word_o) && $stable(flags_o) && $stable(err_o)
                            && $stable(fixed_o) && $stable(uncorr_o)));

    p_status_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({fixed_o, uncorr_o}) && (err_o == (fixed_o || uncorr_o)));

endmodule

bind ecc_cfg_word ecc_cfg_word_chk #(
    .SYN_W    (SYN_W),
    .FLAG_LSB (FLAG_LSB),
    .FLAG_W   (FLAG_W)
) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load_i),
    .word_i   (word_i),
    .word_o   (word_o),
    .flags_o  (flags_o),
    .err_o    (err_o),
    .fixed_o  (fixed_o),
    .uncorr_o (uncorr_o),
    .done_o   (done_o)
);

// File: tb/sim_ecc_cfg_word.sv
module sim_ecc_cfg_word;

    logic        clk = 1'b0;
    logic        rst_ni = 1'b0;
    logic        load_i = 1'b0;
    logic [63:0] word_i = '0;
    logic [63:0] word_o;
    logic [4:0]  flags_o;
    logic        err_o, fixed_o, uncorr_o, done_o;

    int total = 0;
    int bad   = 0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    ecc_cfg_word u0 (
        .clk_i    (clk),
        .rst_ni   (rst_ni),
        .load_i   (load_i),
        .word_i   (word_i),
        .word_o   (word_o),
        .flags_o  (flags_o),
        .err_o    (err_o),
        .fixed_o  (fixed_o),
        .uncorr_o (uncorr_o),
        .done_o   (done_o)
    );

    function automatic bit pw2(int v);
        return (v == 1) || (v == 2) || (v == 4) || (v == 8) || (v == 16) || (v == 32);
    endfunction

    // rebuild all eight check bits from the data bits of w
    function automatic logic [63:0] seal(logic [63:0] w);
        logic [63:0] r = w;
        logic c;
        for (int k = 0; k < 6; k++) begin
            c = 1'b0;
            for (int p = 1; p < 63; p++)
                if (p != (1 << k) && ((p >> k) & 1) == 1) c ^= r[p];
            r[1 << k] = c;
        end
        c = 1'b0;
        for (int p = 3; p < 63; p++) if (!pw2(p)) c ^= r[p];
        r[0] = c;
        r[63] = r[1] ^ r[2] ^ r[4] ^ r[8] ^ r[16] ^ r[32];
        return r;
    endfunction

    function automatic bit good(logic [63:0] w);
        return seal(w) == w;
    endfunction

    // reference model: brute-force search for a single repair
    logic [63:0] exp_word = '0;
    logic        exp_err = 1'b0, exp_fixed = 1'b0, exp_uncorr = 1'b0, exp_done = 1'b0;
    string       exp_req = "R9";

    always @(posedge clk) begin
        if (!rst_ni) begin
            exp_word = '0; exp_err = 0; exp_fixed = 0; exp_uncorr = 0; exp_done = 0;
        end else begin
            exp_done = load_i;
            if (load_i) begin
                exp_req = cur_req;
                exp_word = word_i; exp_err = 0; exp_fixed = 0; exp_uncorr = 0;
                if (!good(word_i)) begin
                    exp_err = 1;
                    exp_uncorr = 1;
                    for (int p = 0; p < 64; p++) begin
                        if (exp_uncorr && good(word_i ^ (64'd1 << p))) begin
                            exp_word = word_i ^ (64'd1 << p);
                            exp_fixed = 1;
                            exp_uncorr = 0;
                        end
                    end
                end
            end
        end
    end

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    // compare against the model on every clock, away from the rising edge
    always @(negedge clk) begin
        if (rst_ni) begin
            chk(exp_req, "word", word_o, exp_word);
            chk("R8", "flags", {59'd0, flags_o}, {59'd0, exp_word[62:58]});
            chk({exp_req, "/R10"}, "status", {61'd0, err_o, fixed_o, uncorr_o},
                {61'd0, exp_err, exp_fixed, exp_uncorr});
            chk("R6", "done", {63'd0, done_o}, {63'd0, exp_done});
        end
    end

    task automatic put(logic [63:0] w, string req);
        @(negedge clk);
        cur_req = req;
        word_i  = w;
        load_i  = 1'b1;
    endtask

    task automatic idle(int n);
        repeat (n) begin
            @(negedge clk);
            cur_req = "R7";
            load_i  = 1'b0;
            word_i  = {$urandom, $urandom};
        end
    endtask

    function automatic logic [63:0] mk(logic [4:0] flg);
        logic [63:0] w = {$urandom, $urandom};
        w[62:58] = flg;
        return seal(w);
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [63:0] base;
        repeat (3) @(negedge clk);
        chk("R9", "reset outputs", {word_o[63:5] | {54'd0, flags_o}, err_o, fixed_o, uncorr_o, done_o},
            64'd0);
        rst_ni = 1'b1;
        idle(2);

        // R1 clean words, both flag variants
        put(mk(5'd1), "R1");
        @(negedge clk);
        load_i = 1'b0;
        chk("R8", "flags protected", {59'd0, flags_o}, 64'd1);
        chk("R1", "clean err", {63'd0, err_o}, 64'd0);
        put(mk(5'd0), "R1");
        put(mk(5'd0), "R1");
        idle(3);

        // single flips at every position: R2 data, R3 Hamming checks, R4 lone parity bits
        for (int p = 0; p < 64; p++) begin
            base = mk(5'(p % 2));
            if (p == 0 || p == 63)  put(base ^ (64'd1 << p), "R4");
            else if (pw2(p))        put(base ^ (64'd1 << p), "R3");
            else                    put(base ^ (64'd1 << p), "R2");
            if (p % 8 == 7) idle(2);
        end
        idle(2);

        // R8 flipped flag bit repaired before exposure
        base = mk(5'd1);
        put(base ^ (64'd1 << 58), "R8");
        @(negedge clk);
        load_i = 1'b0;
        chk("R8", "flag repaired", {59'd0, flags_o}, 64'd1);
        chk("R2", "fixed flag", {63'd0, fixed_o}, 64'd1);
        idle(1);

        // R5 double flips, including the lone parity pair
        put(mk(5'd1) ^ 64'h8000_0000_0000_0001, "R5");
        idle(1);
        chk("R5", "uncorr both parity bits", {63'd0, uncorr_o}, 64'd1);
        for (int i = 0; i < 300; i++) begin
            int a = int'($urandom % 64);
            int b = int'($urandom % 64);
            if (a == b) b = (a + 1) % 64;
            put(mk(5'($urandom)) ^ (64'd1 << a) ^ (64'd1 << b), "R5");
            if (i % 5 == 4) idle(1 + (i % 3));
        end
        idle(4);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule